// File: doc/BRIEF.md
# Reset-Addressed Serial Field Delay Memory

This block is a two-clock serial memory used as a programmable delay line for video fields or lines. Data enters on a write clock and leaves on a read clock. Each side walks through storage with its own address counter. There are no full or empty flags. The only way to control the distance between writer and reader is to drive each side's pointer reset at a chosen moment. A word stored on the n-th write step after a write pointer reset comes out on the n-th read step after a read pointer reset. The two clocks may run at unrelated rates.

Each port has two kinds of enable. A step enable decides whether a clock edge does anything at all on that side: it stores or fetches a word and moves the pointer. A per-lane data enable only gates the data path while the pointer keeps moving. On the write side, a disabled lane leaves its stored byte untouched, so a sub-region of a field can be overwritten and the rest kept. On the read side, a disabled lane delivers zeros, so words are skipped. Byte lanes share both clocks and together form one wide word.

Top module: `field_delay_mem`

## Requirements
- R1: A read pointer reset sampled high on a read clock edge sets the read address to 0 and drives every bit of the read data to 0 after that edge.
- R2: A write pointer reset sampled high on a write clock edge sets the write address to 0 and stores nothing. The first write edge with step enable high after release stores into address 0.
- R3: On the first read edge with step enable high after a read pointer reset is released, the word at address 0 appears on the read data right after that edge, with no added cycle.
- R4: A write clock edge with write step enable low stores nothing and leaves the write address unchanged.
- R5: A read clock edge with read step enable low leaves the read address unchanged and holds the read data at its previous value.
- R6: When write step enable is high and lane data enable bit l is low, lane l's stored byte at the current address is kept, and the write address still advances by one.
- R7: When read step enable is high and lane data enable bit l is low, bits [8l+7:8l] of the read data become 0, and the read address still advances by one.
- R8: Both address counters wrap from DEPTH-1 to 0 on a step.
- R9: The word stored on the n-th write step after a write pointer reset is delivered on the n-th read step after a read pointer reset, counting steps modulo DEPTH.
- R10: Lane l uses bits [8l+7:8l] of the write data and read data and bit l of each lane data enable. Lanes are masked independently of one another.
- R11: Reading an address that has not been rewritten since an earlier pass returns the byte from that earlier pass. No stale-data indication exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write side clock |
| wr_ptr_rst | input | 1 | Write pointer reset, synchronous, active high |
| wr_step | input | 1 | Write step enable: store and advance |
| wr_lane_en | input | LANES | Per-lane write data enable |
| wr_data | input | 8*LANES | Write word, lane l in bits [8l+7:8l] |
| rd_clk | input | 1 | Read side clock |
| rd_ptr_rst | input | 1 | Read pointer reset, synchronous, active high |
| rd_step | input | 1 | Read step enable: fetch and advance |
| rd_lane_en | input | LANES | Per-lane read data enable |
| rd_data | output | 8*LANES | Registered read word |

## Verification
The bench builds the block with DEPTH of 16 and the default two lanes. With that depth, a single write pass of twenty steps crosses the wrap point. A short third pass leaves most of the field holding older bytes, so stale readback (R11) and counter wrap (R8) are both exercised within a few hundred cycles. With two lanes, masking one lane while the other stores or reads shows that the lanes are independent.

// File: rtl/fdl_pkg.sv
package fdl_pkg;
    localparam int LANE_W = 8;
    typedef logic [LANE_W-1:0] lane_t;
endpackage

// File: rtl/fdl_addr_ctr.sv
module fdl_addr_ctr #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          zero,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] addr;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (zero) begin
            st_d.addr = '0;
        end else if (step) begin
            st_d.addr = (st_q.addr == LAST) ? '0 : st_q.addr + AW'(1);
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign addr = st_q.addr;

    // R1 / R2: pointer reset lands on address 0
    a_r1_r2_ptr_zero: assert property (@(posedge clk) zero |=> addr == '0);
    // R4 / R5: no step, no movement
    a_r4_r5_freeze: assert property (@(posedge clk) disable iff (zero)
        !step |=> $stable(addr));
    // R6 / R7: a step advances by one below the top address
    a_r6_r7_advance: assert property (@(posedge clk) disable iff (zero)
        (step && addr != LAST) |=> addr == $past(addr) + AW'(1));
    // R8: wrap at the top address
    a_r8_wrap: assert property (@(posedge clk) disable iff (zero)
        (step && addr == LAST) |=> addr == '0);
endmodule

// File: rtl/fdl_lane_ram.sv
module fdl_lane_ram
    import fdl_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          wr_go,
    input  logic [AW-1:0] wr_addr,
    input  lane_t         wr_byte,
    input  logic          rd_clk,
    input  logic          rd_zero,
    input  logic          rd_go,
    input  logic          rd_show,
    input  logic [AW-1:0] rd_addr,
    output lane_t         rd_byte
);
    typedef struct packed {
        lane_t dat;
    } rd_st_t;

    lane_t  cells [DEPTH];
    rd_st_t rd_d, rd_q;

    always_ff @(posedge wr_clk) begin
        if (wr_go) begin
            cells[wr_addr] <= wr_byte;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_zero) begin
            rd_d.dat = '0;
        end else if (rd_go) begin
            rd_d.dat = rd_show ? cells[rd_addr] : '0;
        end
    end

    always_ff @(posedge rd_clk) begin
        rd_q <= rd_d;
    end

    assign rd_byte = rd_q.dat;

    // R7: a dark lane reads as zero after a step
    a_r7_dark_lane: assert property (@(posedge rd_clk) disable iff (rd_zero)
        (rd_go && !rd_show) |=> rd_byte == '0);
endmodule

// File: rtl/field_delay_mem.sv
module field_delay_mem
    import fdl_pkg::*;
#(
    parameter  int DEPTH = 1024,
    parameter  int LANES = 2,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             wr_clk,
    input  logic             wr_ptr_rst,
    input  logic             wr_step,
    input  logic [LANES-1:0] wr_lane_en,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_clk,
    input  logic             rd_ptr_rst,
    input  logic             rd_step,
    input  logic [LANES-1:0] rd_lane_en,
    output logic [DW-1:0]    rd_data
);
    logic [AW-1:0] wr_addr;
    logic [AW-1:0] rd_addr;

    fdl_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_wr_ctr (
        .clk  (wr_clk),
        .zero (wr_ptr_rst),
        .step (wr_step),
        .addr (wr_addr)
    );

    fdl_addr_ctr #(.DEPTH(DEPTH), .AW(AW)) u_rd_ctr (
        .clk  (rd_clk),
        .zero (rd_ptr_rst),
        .step (rd_step),
        .addr (rd_addr)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic  lane_wr_go;
        lane_t lane_out;

        assign lane_wr_go = wr_step & wr_lane_en[l] & ~wr_ptr_rst;

        fdl_lane_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
            .wr_clk  (wr_clk),
            .wr_go   (lane_wr_go),
            .wr_addr (wr_addr),
            .wr_byte (wr_data[l*LANE_W +: LANE_W]),
            .rd_clk  (rd_clk),
            .rd_zero (rd_ptr_rst),
            .rd_go   (rd_step),
            .rd_show (rd_lane_en[l]),
            .rd_addr (rd_addr),
            .rd_byte (lane_out)
        );

        assign rd_data[l*LANE_W +: LANE_W] = lane_out;

        // R10: a dark lane on the output port is zero, independent of others
        a_r10_lane_port_dark: assert property (@(posedge rd_clk) disable iff (rd_ptr_rst)
            (rd_step && !rd_lane_en[l]) |=> rd_data[l*LANE_W +: LANE_W] == '0);
    end

    // R1: read pointer reset clears the output word
    a_r1_dout_clear: assert property (@(posedge rd_clk) rd_ptr_rst |=> rd_data == '0);
    // R5: no read step, output word held
    a_r5_dout_hold: assert property (@(posedge rd_clk) disable iff (rd_ptr_rst)
        !rd_step |=> $stable(rd_data));
endmodule

// File: tb/test_field_delay_mem.sv
module test_field_delay_mem;
    localparam int DEPTH = 16;
    localparam int LANES = 2;
    localparam int DW    = LANES * 8;

    logic             wr_clk = 1'b0;
    logic             rd_clk = 1'b0;
    logic             wr_ptr_rst = 1'b1;
    logic             wr_step = 1'b0;
    logic [LANES-1:0] wr_lane_en = '0;
    logic [DW-1:0]    wr_data = '0;
    logic             rd_ptr_rst = 1'b1;
    logic             rd_step = 1'b0;
    logic [LANES-1:0] rd_lane_en = '0;
    logic [DW-1:0]    rd_data;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.5 rd_clk = ~rd_clk;

    field_delay_mem #(.DEPTH(DEPTH), .LANES(LANES)) i_field_delay_mem (
        .wr_clk     (wr_clk),
        .wr_ptr_rst (wr_ptr_rst),
        .wr_step    (wr_step),
        .wr_lane_en (wr_lane_en),
        .wr_data    (wr_data),
        .rd_clk     (rd_clk),
        .rd_ptr_rst (rd_ptr_rst),
        .rd_step    (rd_step),
        .rd_lane_en (rd_lane_en),
        .rd_data    (rd_data)
    );

    // behavioural reference
    logic [7:0]    ref_mem [LANES][DEPTH];
    int            ref_wp = 0;
    int            ref_rp = 0;
    logic [DW-1:0] ref_out;
    bit            armed = 0;
    int            vectors = 0;
    int            fails = 0;
    bit            done = 0;
    string         cur_req = "R1";

    always @(posedge wr_clk) begin
        if (wr_ptr_rst) begin
            ref_wp = 0;
        end else if (wr_step) begin
            for (int l = 0; l < LANES; l++)
                if (wr_lane_en[l]) ref_mem[l][ref_wp] = wr_data[l*8 +: 8];
            ref_wp = (ref_wp + 1) % DEPTH;
        end
    end

    always @(posedge rd_clk) begin
        if (rd_ptr_rst) begin
            ref_rp  = 0;
            ref_out = '0;
            armed   = 1;
        end else if (rd_step) begin
            for (int l = 0; l < LANES; l++)
                ref_out[l*8 +: 8] = rd_lane_en[l] ? ref_mem[l][ref_rp] : 8'h00;
            ref_rp = (ref_rp + 1) % DEPTH;
        end
    end

    always @(negedge rd_clk) begin
        if (armed && !done) begin
            vectors++;
            if (rd_data !== ref_out) begin
                fails++;
                $display("FAIL %s: rd_data actual %h expected %h at %0t",
                         cur_req, rd_data, ref_out, $time);
            end
        end
    end

    task automatic wr_cyc(input bit rst, input bit st, input logic [LANES-1:0] en,
                          input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_ptr_rst = rst; wr_step = st; wr_lane_en = en; wr_data = d;
    endtask

    task automatic rd_cyc(input bit rst, input bit st, input logic [LANES-1:0] en);
        @(negedge rd_clk);
        rd_ptr_rst = rst; rd_step = st; rd_lane_en = en;
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        // R1: both pointer resets held, output word must be zero
        cur_req = "R1";
        repeat (4) rd_cyc(1, 0, '0);
        repeat (4) wr_cyc(1, 0, '0, '0);
        rd_cyc(0, 0, '0);
        // R5: read side idles (no step) while writes happen; output held
        cur_req = "R5";
        // pass 1, R2 R8: twenty full writes, addresses wrap past DEPTH-1
        for (int i = 0; i < 20; i++)
            wr_cyc(0, 1, 2'b11, {8'(i * 3 + 1), 8'(8'hC0 + i)});
        // pass 2, R4 R6 R10: random step and per-lane masking
        wr_cyc(1, 0, '0, '0);
        for (int i = 0; i < 24; i++)
            wr_cyc(0, 1'($urandom), 2'($urandom), 16'($urandom));
        // pass 3, R11: rewrite only the first six words
        wr_cyc(1, 0, '0, '0);
        for (int i = 0; i < 6; i++)
            wr_cyc(0, 1, 2'b11, {8'h50 + 8'(i), 8'hA0 + 8'(i)});
        wr_cyc(0, 0, '0, '0);
        repeat (6) wr_cyc(0, 0, '0, '0);
        // R3 R9 R11: read the whole field in order after a read reset
        cur_req = "R3 R9 R11";
        rd_cyc(1, 0, '0);
        for (int i = 0; i < DEPTH; i++) rd_cyc(0, 1, 2'b11);
        // R5 R7 R8 R10: random stepping and lane skipping across wraps
        cur_req = "R5 R7 R8 R10";
        for (int i = 0; i < 60; i++) rd_cyc(0, 1'($urandom), 2'($urandom));
        // R1 again mid-stream
        cur_req = "R1";
        rd_cyc(1, 1, 2'b11);
        cur_req = "R3";
        rd_cyc(0, 1, 2'b01);
        rd_cyc(0, 1, 2'b10);
        rd_cyc(0, 0, 2'b00);
        repeat (3) @(negedge rd_clk);
        finish_run();
    end
endmodule